// File: doc/BRIEF.md
# Chainable Up/Down Binary Counter

This block is a synchronous binary counter of parameterised width (four bits by default). On each rising clock edge it does one of four things: take a parallel value, step up by one, step down by one, or hold. A low-active load strobe loads the parallel value and overrides every other control. Counting needs two low-active enables at once. The first is a local count enable. The second is a chain enable that carries the ripple condition from a lower stage. A direction input selects increment or decrement.

Wider counters are built by chaining. The active-low terminal flag goes low when the count sits at its top value while counting up, or at zero while counting down, and only while the chain enable is low. That flag feeds the chain enable of the next stage. Every stage shares one clock, so the whole chain advances in step. The flag is a combinational decode of the stored count, the direction and the chain enable. The local count enable has no effect on it. The counter has no reset, so software or a test harness gives it a known value through a first load.

Top module: `ucnt_cascade`

## Requirements
- R1: While ld_n is 0, the next rising edge stores ld_data into q, whatever cnt_en_n, chain_en_n and dir_up are doing.
- R2: With ld_n=1, cnt_en_n=0, chain_en_n=0 and dir_up=1, each rising edge adds one to q.
- R3: With ld_n=1, cnt_en_n=0, chain_en_n=0 and dir_up=0, each rising edge subtracts one from q.
- R4: With ld_n=1 and cnt_en_n=1, q keeps its value across the edge.
- R5: With ld_n=1 and chain_en_n=1, q keeps its value across the edge.
- R6: The count wraps. An increment from the all-ones value gives 0, and a decrement from 0 gives all-ones.
- R7: term_n is 0 exactly when chain_en_n=0 and either (dir_up=1 and q is all-ones) or (dir_up=0 and q=0). In every other case it is 1.
- R8: term_n does not depend on cnt_en_n.
- R9: term_n is combinational. It follows changes on dir_up and chain_en_n within the same clock cycle, with no clock edge needed.
- R10: When each stage's term_n drives the next stage's chain_en_n, two 4-bit stages on a shared clock count as one 8-bit counter in both directions, across the 8'hFF/8'h00 boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| ld_n | input | 1 | Parallel load strobe, active low |
| ld_data | input | WIDTH | Value stored on load |
| cnt_en_n | input | 1 | Local count enable, active low |
| chain_en_n | input | 1 | Chain enable, active low; also gates term_n |
| dir_up | input | 1 | 1 selects increment, 0 selects decrement |
| q | output | WIDTH | Current count |
| term_n | output | 1 | Terminal flag, active low |

## Verification
The hardest case to reach is a chained pair whose upper stage must advance in exactly the cycle the lower stage wraps. A fault there shows up only at one boundary per 16 counts, and only in one direction at a time. The stimulus loads the pair just below 8'hFF, counts up through the wrap, then loads just above 8'h00 and counts down through it, checking the 8-bit value each cycle. On a single stage, loads are placed at 15 and 0, and the direction is reversed right at those values, so that each half of the terminal decode is hit at its edge.

// File: rtl/ucnt_pkg.sv
`timescale 1ns/1ps
package ucnt_pkg;
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_UP   = 2'd2,
      OP_DOWN = 2'd3
   } ucnt_op_e;

   localparam int unsigned IMPL_ADDER  = 0;
   localparam int unsigned IMPL_TOGGLE = 1;
endpackage

// File: rtl/ucnt_mode_dec.sv
`timescale 1ns/1ps
module ucnt_mode_dec
   import ucnt_pkg::*;
(
   input  logic     ld_n,
   input  logic     cnt_en_n,
   input  logic     chain_en_n,
   input  logic     dir_up,
   output ucnt_op_e op
);
   always_comb begin
      if (!ld_n)
         op = OP_LOAD;
      else if (!cnt_en_n && !chain_en_n)
         op = dir_up ? OP_UP : OP_DOWN;
      else
         op = OP_HOLD;
   end
endmodule

// File: rtl/ucnt_step.sv
`timescale 1ns/1ps
module ucnt_step
   import ucnt_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned IMPL  = IMPL_ADDER
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             dir_up,
   output logic [WIDTH-1:0] stepped
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   generate
      if (IMPL == IMPL_ADDER) begin : g_adder
         always_comb stepped = dir_up ? cur + ONE : cur - ONE;
      end else begin : g_toggle
         logic [WIDTH:0] carry;
         assign carry[0] = 1'b1;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign carry[i+1]  = carry[i] & (dir_up ? cur[i] : ~cur[i]);
            assign stepped[i]  = cur[i] ^ carry[i];
         end
      end
   endgenerate
endmodule

// File: rtl/ucnt_term.sv
`timescale 1ns/1ps
module ucnt_term #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             dir_up,
   input  logic             chain_en_n,
   output logic             term_n
);
   logic at_top;
   logic at_zero;

   assign at_top  = &cur;
   assign at_zero = ~|cur;

   always_comb begin
      term_n = 1'b1;
      if (!chain_en_n)
         term_n = dir_up ? ~at_top : ~at_zero;
   end
endmodule

// File: rtl/ucnt_cascade.sv
`timescale 1ns/1ps
module ucnt_cascade
   import ucnt_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned IMPL  = IMPL_ADDER
) (
   input  logic             clk,
   input  logic             ld_n,
   input  logic [WIDTH-1:0] ld_data,
   input  logic             cnt_en_n,
   input  logic             chain_en_n,
   input  logic             dir_up,
   output logic [WIDTH-1:0] q,
   output logic             term_n
);
   generate
      if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
         $error("ucnt_cascade: WIDTH must be 1..32");
      end
      if (IMPL != IMPL_ADDER && IMPL != IMPL_TOGGLE) begin : g_bad_impl
         $error("ucnt_cascade: IMPL selects an unknown variant");
      end
   endgenerate

   ucnt_op_e         op;
   logic [WIDTH-1:0] cnt_r;
   logic [WIDTH-1:0] stepped;
   logic [WIDTH-1:0] cnt_nxt;

   ucnt_mode_dec u_dec (
      .ld_n       (ld_n),
      .cnt_en_n   (cnt_en_n),
      .chain_en_n (chain_en_n),
      .dir_up     (dir_up),
      .op         (op)
   );

   ucnt_step #(.WIDTH(WIDTH), .IMPL(IMPL)) u_step (
      .cur     (cnt_r),
      .dir_up  (dir_up),
      .stepped (stepped)
   );

   ucnt_term #(.WIDTH(WIDTH)) u_term (
      .cur        (cnt_r),
      .dir_up     (dir_up),
      .chain_en_n (chain_en_n),
      .term_n     (term_n)
   );

   always_comb begin
      unique case (op)
         OP_LOAD:        cnt_nxt = ld_data;
         OP_UP, OP_DOWN: cnt_nxt = stepped;
         default:        cnt_nxt = cnt_r;
      endcase
   end

   always_ff @(posedge clk) cnt_r <= cnt_nxt;

   assign q = cnt_r;
endmodule

// File: rtl/ucnt_cascade_chk.sv
`timescale 1ns/1ps
module ucnt_cascade_chk #(
   parameter int unsigned WIDTH = 4
) (
   input logic             clk,
   input logic             ld_n,
   input logic [WIDTH-1:0] ld_data,
   input logic             cnt_en_n,
   input logic             chain_en_n,
   input logic             dir_up,
   input logic [WIDTH-1:0] q,
   input logic             term_n
);
   localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

   // the counter has no reset; checks start after the first load edge
   logic primed = 1'b0;
   always_ff @(posedge clk) if (!ld_n) primed <= 1'b1;

   assert_load_wins_R1: assert property (@(posedge clk) disable iff (!primed)
      !ld_n |=> q == $past(ld_data));

   assert_count_up_R2: assert property (@(posedge clk) disable iff (!primed)
      (ld_n && !cnt_en_n && !chain_en_n && dir_up) |=> q == $past(q) + ONE);

   assert_count_down_R3: assert property (@(posedge clk) disable iff (!primed)
      (ld_n && !cnt_en_n && !chain_en_n && !dir_up) |=> q == $past(q) - ONE);

   assert_hold_local_R4: assert property (@(posedge clk) disable iff (!primed)
      (ld_n && cnt_en_n) |=> $stable(q));

   assert_hold_chain_R5: assert property (@(posedge clk) disable iff (!primed)
      (ld_n && chain_en_n) |=> $stable(q));

   assert_term_needs_chain_R7: assert property (@(posedge clk) disable iff (!primed)
      chain_en_n |-> term_n);

   assert_term_at_end_R7: assert property (@(posedge clk) disable iff (!primed)
      !term_n |-> (dir_up ? (q == ALL1) : (q == '0)));
endmodule

bind ucnt_cascade ucnt_cascade_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/ucnt_cascade_test.sv
`timescale 1ns/1ps
module ucnt_cascade_test;
   logic       clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // single stage under test
   logic       ld_n = 1'b1, cnt_en_n = 1'b1, chain_en_n = 1'b1, dir_up = 1'b1;
   logic [3:0] ld_data = '0;
   logic [3:0] q;
   logic       term_n;

   ucnt_cascade uut (
      .clk(clk), .ld_n(ld_n), .ld_data(ld_data), .cnt_en_n(cnt_en_n),
      .chain_en_n(chain_en_n), .dir_up(dir_up), .q(q), .term_n(term_n));

   // two-stage chain
   logic       c_ld_n = 1'b1, c_en_n = 1'b1, c_up = 1'b1;
   logic [7:0] c_data = '0;
   logic [3:0] lo_q, hi_q;
   logic       lo_term_n, hi_term_n;

   ucnt_cascade u_lo (
      .clk(clk), .ld_n(c_ld_n), .ld_data(c_data[3:0]), .cnt_en_n(1'b0),
      .chain_en_n(c_en_n), .dir_up(c_up), .q(lo_q), .term_n(lo_term_n));
   ucnt_cascade u_hi (
      .clk(clk), .ld_n(c_ld_n), .ld_data(c_data[7:4]), .cnt_en_n(c_en_n),
      .chain_en_n(lo_term_n), .dir_up(c_up), .q(hi_q), .term_n(hi_term_n));

   task automatic chk(input int act, input int exp, input string req);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   // {ld_n, ld_data[3:0], cnt_en_n, chain_en_n, dir_up, exp_q[3:0], exp_term_n}
   localparam int NV = 17;
   localparam logic [12:0] VEC [NV] = '{
      {1'b0, 4'd5,  1'b1, 1'b1, 1'b1, 4'd5,  1'b1}, // R1 load, enables off
      {1'b1, 4'd0,  1'b0, 1'b0, 1'b1, 4'd6,  1'b1}, // R2
      {1'b1, 4'd0,  1'b0, 1'b0, 1'b1, 4'd7,  1'b1}, // R2
      {1'b1, 4'd0,  1'b1, 1'b0, 1'b1, 4'd7,  1'b1}, // R4
      {1'b1, 4'd0,  1'b0, 1'b1, 1'b1, 4'd7,  1'b1}, // R5
      {1'b0, 4'd14, 1'b0, 1'b0, 1'b1, 4'd14, 1'b1}, // R1 load over active count
      {1'b1, 4'd0,  1'b0, 1'b0, 1'b1, 4'd15, 1'b0}, // R2 R7 top while up
      {1'b1, 4'd0,  1'b1, 1'b0, 1'b1, 4'd15, 1'b0}, // R4 R8 flag ignores local enable
      {1'b1, 4'd0,  1'b0, 1'b0, 1'b1, 4'd0,  1'b1}, // R6 wrap up
      {1'b1, 4'd0,  1'b0, 1'b0, 1'b0, 4'd15, 1'b1}, // R6 wrap down, R7 top while down
      {1'b1, 4'd0,  1'b0, 1'b0, 1'b0, 4'd14, 1'b1}, // R3
      {1'b0, 4'd1,  1'b0, 1'b0, 1'b0, 4'd1,  1'b1}, // R1
      {1'b1, 4'd0,  1'b0, 1'b0, 1'b0, 4'd0,  1'b0}, // R3 R7 zero while down
      {1'b1, 4'd0,  1'b0, 1'b1, 1'b0, 4'd0,  1'b1}, // R5 R7 chain enable off
      {1'b1, 4'd0,  1'b0, 1'b0, 1'b1, 4'd1,  1'b1}, // R2 reverse at zero
      {1'b0, 4'd15, 1'b0, 1'b0, 1'b1, 4'd15, 1'b0}, // R1 R7
      {1'b1, 4'd0,  1'b0, 1'b0, 1'b0, 4'd14, 1'b1}  // R3 reverse at top
   };

   initial begin
      #(8 * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not end)");
      finish_run();
   end

   initial begin
      // walk the vector table
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ld_n       = VEC[i][12];
         ld_data    = VEC[i][11:8];
         cnt_en_n   = VEC[i][7];
         chain_en_n = VEC[i][6];
         dir_up     = VEC[i][5];
         @(posedge clk);
         #2;
         chk(int'(q),      int'(VEC[i][4:1]), $sformatf("R1-6 vec%0d q", i));
         chk(int'(term_n), int'(VEC[i][0]),   $sformatf("R7 vec%0d term_n", i));
      end

      // R9 combinational flag: change controls with no clock edge
      @(negedge clk);
      ld_n = 1'b0; ld_data = 4'd0; chain_en_n = 1'b1; dir_up = 1'b0; cnt_en_n = 1'b1;
      @(posedge clk); #2;
      ld_n = 1'b1;
      chk(int'(q), 0, "R1 load zero");
      chk(int'(term_n), 1, "R9 chain off");
      #1 chain_en_n = 1'b0;
      #1 chk(int'(term_n), 0, "R9 chain on at zero down");
      cnt_en_n = 1'b0;
      #0.5 chk(int'(term_n), 0, "R8 local enable low");
      cnt_en_n = 1'b1;
      #0.5 chk(int'(term_n), 0, "R8 local enable high");
      dir_up = 1'b1;
      #1 chk(int'(term_n), 1, "R9 direction flip");
      chain_en_n = 1'b1;
      @(posedge clk); #2;
      chk(int'(q), 0, "R4 hold after flag probes");

      // R10 8-bit chain, counting up across FF->00
      @(negedge clk);
      c_ld_n = 1'b0; c_data = 8'hFD; c_up = 1'b1; c_en_n = 1'b1;
      @(posedge clk); #2;
      chk(int'({hi_q, lo_q}), 8'hFD, "R10 chain load");
      @(negedge clk);
      c_ld_n = 1'b1; c_en_n = 1'b0;
      for (int k = 1; k <= 5; k++) begin
         @(posedge clk); #2;
         chk(int'({hi_q, lo_q}), int'(8'(8'hFD + k)), "R10 chain up");
      end
      chk(int'(hi_term_n), 1, "R10 upper flag mid-range up");

      // R10 8-bit chain, counting down across 00->FF
      @(negedge clk);
      c_ld_n = 1'b0; c_data = 8'h02; c_up = 1'b0;
      @(posedge clk); #2;
      chk(int'({hi_q, lo_q}), 8'h02, "R10 chain load down start");
      @(negedge clk);
      c_ld_n = 1'b1;
      for (int k = 1; k <= 5; k++) begin
         @(posedge clk); #2;
         chk(int'({hi_q, lo_q}), int'(8'(8'h02 - k)), "R10 chain down");
      end

      // R10 chain hold when the shared enable is off
      @(negedge clk);
      c_en_n = 1'b1;
      @(posedge clk); #2;
      chk(int'({hi_q, lo_q}), 8'hFD, "R10 chain hold");

      finish_run();
   end
endmodule